// File: doc/BRIEF.md
# Serial MSB-First Magnitude Comparator

This block decides which of two unsigned numbers is larger when both arrive one bit per clock on two serial lines, most significant bit first. A synchronous, active-high reset clears the decision and starts a new comparison; the first bit pair is taken on the first clock after reset is released. Because the numbers arrive most significant bit first, the first bit position at which the two lines differ settles the result for the whole word. The block then holds that result until the next reset, whatever bits follow.

The control is a three-state machine. `ST_UNDECIDED` is entered by reset and kept while the two incoming bits match. The transition `UNDECIDED->A_GT` is taken on a pair with A=1, B=0, and `UNDECIDED->A_LT` on a pair with A=0, B=1. `A_GT` and `A_LT` have only self-loops; the only way out is reset, which goes back to `UNDECIDED` from any state. The verdict outputs are Mealy outputs. They rise in the same cycle as the first differing bit pair, one clock before the state register records the decision. The block does not track word length; the user frames each word with reset.

Top module: `serial_mag_cmp`

## Requirements
- R1: On the first cycle after reset is released, both outputs are low when the two input bits are equal.
- R2: In the undecided state, an input pair with A=1 and B=0 drives `a_gt` high in that same cycle, before the next clock edge.
- R3: In the undecided state, an input pair with A=0 and B=1 drives `a_lt` high in that same cycle, before the next clock edge.
- R4: While undecided, equal input bits keep both outputs low and leave the machine undecided.
- R5: Once `a_gt` has gone high, it stays high and `a_lt` stays low on every later cycle until reset, whatever the input bits are.
- R6: Once `a_lt` has gone high, it stays high and `a_gt` stays low on every later cycle until reset, whatever the input bits are.
- R7: `a_gt` and `a_lt` are never high together.
- R8: While `rst` is high, both outputs are low whatever the state or the inputs, and the next clock edge returns the machine to undecided.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; bits are taken on its rising edge |
| rst | input | 1 | Synchronous active-high reset; starts a new comparison |
| bit_a | input | 1 | Serial bit of operand A, most significant bit first |
| bit_b | input | 1 | Serial bit of operand B, most significant bit first |
| a_gt | output | 1 | High when A is found greater than B |
| a_lt | output | 1 | High when A is found less than B |

## Verification
Two events can fall in the same cycle: the first differing bit pair, which raises a verdict combinationally, and the state update, which does not register that verdict until the following edge. The bench provokes this on every vector by driving each bit pair between edges and sampling the outputs before the edge. It compares them with a reference magnitude compare on the bits received so far, so a verdict that arrives one cycle late shows up as a miscompare on exactly that bit. A second case joins reset with a decided state and opposing inputs, and the bench expects the outputs to go quiet during that same reset cycle.

// File: rtl/serial_mag_cmp_pkg.sv
package serial_mag_cmp_pkg;
    localparam int STATE_W = 2;

    typedef enum logic [STATE_W-1:0] {
        ST_UNDECIDED = 2'd0,
        ST_A_GT      = 2'd1,
        ST_A_LT      = 2'd2
    } cmp_state_t;
endpackage

// File: rtl/serial_mag_cmp_next.sv
module serial_mag_cmp_next
    import serial_mag_cmp_pkg::*;
(
    input  cmp_state_t cur_state,
    input  logic       bit_a,
    input  logic       bit_b,
    output cmp_state_t nxt_state
);
    always_comb begin
        nxt_state = cur_state;
        unique case (cur_state)
            ST_UNDECIDED: begin
                if (bit_a && !bit_b)
                    nxt_state = ST_A_GT;
                else if (!bit_a && bit_b)
                    nxt_state = ST_A_LT;
            end
            ST_A_GT: nxt_state = ST_A_GT;
            ST_A_LT: nxt_state = ST_A_LT;
            default: nxt_state = ST_UNDECIDED;
        endcase
    end
endmodule

// File: rtl/serial_mag_cmp_verdict.sv
module serial_mag_cmp_verdict
    import serial_mag_cmp_pkg::*;
(
    input  cmp_state_t cur_state,
    input  logic       rst,
    input  logic       bit_a,
    input  logic       bit_b,
    output logic       a_gt,
    output logic       a_lt
);
    always_comb begin
        a_gt = 1'b0;
        a_lt = 1'b0;
        if (!rst) begin
            unique case (cur_state)
                ST_UNDECIDED: begin
                    a_gt = bit_a && !bit_b;
                    a_lt = !bit_a && bit_b;
                end
                ST_A_GT: a_gt = 1'b1;
                ST_A_LT: a_lt = 1'b1;
                default: begin
                    a_gt = 1'b0;
                    a_lt = 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/serial_mag_cmp.sv
module serial_mag_cmp
    import serial_mag_cmp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_a,
    input  logic bit_b,
    output logic a_gt,
    output logic a_lt
);
    cmp_state_t state_q;
    cmp_state_t state_d;

    serial_mag_cmp_next u_next (
        .cur_state (state_q),
        .bit_a     (bit_a),
        .bit_b     (bit_b),
        .nxt_state (state_d)
    );

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_UNDECIDED;
        else
            state_q <= state_d;
    end

    serial_mag_cmp_verdict u_verdict (
        .cur_state (state_q),
        .rst       (rst),
        .bit_a     (bit_a),
        .bit_b     (bit_b),
        .a_gt      (a_gt),
        .a_lt      (a_lt)
    );
endmodule

// File: rtl/serial_mag_cmp_chk.sv
module serial_mag_cmp_chk (
    input logic clk,
    input logic rst,
    input logic bit_a,
    input logic bit_b,
    input logic a_gt,
    input logic a_lt
);
    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && (bit_a == bit_b)) |-> (!a_gt && !a_lt));

    p_gt_rises_on_pair_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(a_gt) |-> (bit_a && !bit_b));

    p_lt_rises_on_pair_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(a_lt) |-> (!bit_a && bit_b));

    p_gt_sticks_r5: assert property (@(posedge clk) disable iff (rst)
        a_gt |=> (a_gt && !a_lt));

    p_lt_sticks_r6: assert property (@(posedge clk) disable iff (rst)
        a_lt |=> (a_lt && !a_gt));

    p_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
        !(a_gt && a_lt));

    p_reset_quiet_r8: assert property (@(posedge clk)
        rst |-> (!a_gt && !a_lt));
endmodule

bind serial_mag_cmp serial_mag_cmp_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .bit_a (bit_a),
    .bit_b (bit_b),
    .a_gt  (a_gt),
    .a_lt  (a_lt)
);

// File: tb/tb_serial_mag_cmp.sv
module tb_serial_mag_cmp;
    localparam int WORD_W = 8;
    localparam int N_VEC  = 12;
    localparam int N_RAND = 40;

    localparam logic [2*WORD_W-1:0] VEC [N_VEC] = '{
        {8'h00, 8'h00}, {8'hFF, 8'hFF}, {8'hA5, 8'hA5}, {8'h80, 8'h7F},
        {8'h7F, 8'h80}, {8'h01, 8'h00}, {8'h00, 8'h01}, {8'hFF, 8'h00},
        {8'h00, 8'hFF}, {8'h5A, 8'h5B}, {8'hC3, 8'hC1}, {8'h3C, 8'h3C}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_a = 1'b0;
    logic bit_b = 1'b0;
    logic a_gt, a_lt;
    int   n_chk  = 0;
    int   n_fail = 0;

    always #2 clk = ~clk;

    serial_mag_cmp dut (
        .clk(clk), .rst(rst), .bit_a(bit_a), .bit_b(bit_b),
        .a_gt(a_gt), .a_lt(a_lt)
    );

    task automatic check(input string tag, input logic eg, input logic el);
        n_chk++;
        if (a_gt !== eg || a_lt !== el) begin
            n_fail++;
            $display("FAIL %s: a_gt/a_lt=%b%b expected %b%b at %0t",
                     tag, a_gt, a_lt, eg, el, $time);
        end
    endtask

    task automatic reset_cycle();
        @(negedge clk);
        rst = 1'b1; bit_a = 1'b1; bit_b = 1'b0;
        #1 check("R8", 1'b0, 1'b0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_word(input logic [WORD_W-1:0] a, input logic [WORD_W-1:0] b);
        reset_cycle();
        for (int k = 0; k < WORD_W; k++) begin
            logic [WORD_W-1:0] pa, pb, pa_prev, pb_prev;
            string tag;
            if (k > 0) @(negedge clk);
            bit_a = a[WORD_W-1-k];
            bit_b = b[WORD_W-1-k];
            pa = a >> (WORD_W-1-k);
            pb = b >> (WORD_W-1-k);
            pa_prev = a >> (WORD_W-k);
            pb_prev = b >> (WORD_W-k);
            if (k > 0 && pa_prev > pb_prev)      tag = "R5";
            else if (k > 0 && pa_prev < pb_prev) tag = "R6";
            else if (pa > pb)                    tag = "R2";
            else if (pa < pb)                    tag = "R3";
            else if (k == 0)                     tag = "R1";
            else                                 tag = "R4";
            #1 check(tag, pa > pb, pa < pb);
            if (a_gt && a_lt) check("R7", 1'b0, 1'b0);
        end
    endtask

    initial begin
        repeat (2) @(negedge clk);
        for (int v = 0; v < N_VEC; v++)
            run_word(VEC[v][2*WORD_W-1:WORD_W], VEC[v][WORD_W-1:0]);
        for (int v = 0; v < N_RAND; v++)
            run_word(WORD_W'($urandom), WORD_W'($urandom));

        // R8: reset from a decided state with opposing inputs
        run_word(8'hF0, 8'h0F);
        @(negedge clk);
        bit_a = 1'b0; bit_b = 1'b1;
        #1 check("R5", 1'b1, 1'b0);
        @(negedge clk);
        rst = 1'b1;
        #1 check("R8", 1'b0, 1'b0);
        @(negedge clk);
        rst = 1'b0; bit_a = 1'b1; bit_b = 1'b1;
        #1 check("R1", 1'b0, 1'b0);
        @(negedge clk);
        bit_a = 1'b0; bit_b = 1'b1;
        #1 check("R3", 1'b0, 1'b1);
        @(negedge clk);
        bit_a = 1'b1; bit_b = 1'b0;
        #1 check("R6", 1'b0, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule